// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM each time a host asks for it. The host presents a 6-bit word address with a single-cycle start pulse. The block then runs the whole serial exchange by itself: it drives chip select, the serial clock and the command data line toward the memory, and it samples the memory's data line. When the exchange is over, it returns the word together with a one-cycle done pulse.

Every access has four parts. First comes a flushing train of clocks with chip select held high, followed by a short deselect. Next, an 11-bit read command is shifted out. Then 16 data bits are shifted in. Last, a second flushing train and deselect close the access. A divider stretches each half of the serial clock to a fixed number of system clock cycles. That number is derived from the system clock frequency and a minimum phase time in nanoseconds, with a floor of two cycles.

Top module: `mw_eeprom_reader`

## Requirements
- R1: The command word is 11'h180 OR the 6-bit word address. Its 11 bits are shifted out starting with the bit of weight 11'h400. Each bit appears on `ee_di_o` before the rising serial clock edge that carries it and stays there through the following high phase.
- R2: After the command, 16 data bits are taken in MSB first. Each bit is sampled from `ee_do_i` at the end of a high phase of the serial clock. The word is presented on `data_o`, with bit 15 being the first bit received.
- R3: Before the command, chip select is held high for exactly 26 rising serial clock edges. The clock is then held low for one more phase, after which chip select is dropped for one phase.
- R4: After the 16th data bit, chip select remains high for exactly 26 further rising edges. One low phase and a deselect follow, and only then is `done_o` raised.
- R5: Every high phase of the serial clock lasts exactly PHASE_CYC system clock cycles, and every low phase with chip select high lasts at least PHASE_CYC cycles. PHASE_CYC is CLK_HZ/1e6 × PHASE_NS/1000, but never less than 2.
- R6: `busy_o` rises on the cycle after an accepted start. `done_o` is a single-cycle pulse that comes exactly when `busy_o` falls. `data_o` keeps its value until the next access completes.
- R7: A start pulse that arrives while `busy_o` is high is ignored. It does not change the address being read, and it does not cause a second access.
- R8: `ee_di_o` is low whenever no command bit is being presented. This covers the flushing trains, the data phase and idle.
- R9: After reset, and at any time the block is not busy, chip select, serial clock and `ee_di_o` are low. After reset, `busy_o`, `done_o` and `data_o` are zero. A reset in the middle of an access abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to read a word |
| addr_i | input | 6 | Word address, captured with start_i |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse when data_o is updated |
| data_o | output | 16 | Last word read |
| ee_cs_o | output | 1 | Chip select to the EEPROM |
| ee_sk_o | output | 1 | Serial clock to the EEPROM |
| ee_di_o | output | 1 | Command data to the EEPROM |
| ee_do_i | input | 1 | Data from the EEPROM |

## Verification
An access lasts 162 × PHASE_CYC cycles, measured from the cycle after start to the done pulse. Because of that, the bench never predicts an absolute cycle for `done_o`. Instead, it waits at falling clock edges until done is seen, and then checks the word, `busy_o` and the serial frames recorded during the access.

The serial pins are registered and lag the internal phase counter by one cycle. For that reason, all pin timing is judged on run lengths measured between serial clock edges, not on absolute cycles. The EEPROM model in the bench drives each data bit right after the rising edge that requests it. The block samples that bit PHASE_CYC−1 cycles later, still inside the same high phase.

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int PHASE_NS   = 2000,
  parameter int IDLE_PAIRS = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [5:0]  addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] data_o,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i
);
  localparam int PHASE_RAW  = (CLK_HZ / 1_000_000) * PHASE_NS / 1000;
  localparam int PHASE_CYC  = (PHASE_RAW < 2) ? 2 : PHASE_RAW;
  localparam int CW         = $clog2(PHASE_CYC);
  localparam int CMD_BITS   = 11;
  localparam int WORD_BITS  = 16;
  localparam int IDLE_STEPS = 2 * IDLE_PAIRS + 2;
  localparam int CMD_STEPS  = 2 * CMD_BITS;
  localparam int RD_STEPS   = 2 * WORD_BITS;
  localparam int MAX_STEPS  = (IDLE_STEPS > RD_STEPS) ? IDLE_STEPS : RD_STEPS;
  localparam int SW         = $clog2(MAX_STEPS);
  localparam logic [CMD_BITS-1:0] READ_CMD = 11'h180;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_CMD, ST_RD, ST_POST} st_t;

  st_t                  state;
  logic [CW-1:0]        cnt;
  logic [SW-1:0]        step, last_step;
  logic [CMD_BITS-1:0]  cmd_sh;
  logic [WORD_BITS-1:0] data_sh;
  logic                 cs_d, sk_d, di_d;
  logic                 phase_end, flush;

  assign phase_end = (cnt == CW'(PHASE_CYC - 1));
  assign flush     = (state == ST_PRE) || (state == ST_POST);

  always_comb begin
    case (state)
      ST_PRE, ST_POST: last_step = SW'(IDLE_STEPS - 1);
      ST_CMD:          last_step = SW'(CMD_STEPS - 1);
      ST_RD:           last_step = SW'(RD_STEPS - 1);
      default:         last_step = '0;
    endcase
  end

  always_comb begin
    cs_d = 1'b0;
    sk_d = 1'b0;
    di_d = 1'b0;
    if (flush) begin
      cs_d = (step != last_step);
      sk_d = (step < SW'(2 * IDLE_PAIRS)) && step[0];
    end else if (state == ST_CMD) begin
      cs_d = 1'b1;
      sk_d = step[0];
      di_d = cmd_sh[CMD_BITS-1];
    end else if (state == ST_RD) begin
      cs_d = 1'b1;
      sk_d = step[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      step    <= '0;
      cmd_sh  <= '0;
      data_sh <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      ee_cs_o <= 1'b0;
      ee_sk_o <= 1'b0;
      ee_di_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      ee_cs_o <= cs_d;
      ee_sk_o <= sk_d;
      ee_di_o <= di_d;
      if (state == ST_IDLE) begin
        if (start_i) begin
          state  <= ST_PRE;
          step   <= '0;
          cnt    <= '0;
          busy_o <= 1'b1;
          cmd_sh <= READ_CMD | {5'b0, addr_i};
        end
      end else if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (state == ST_CMD && step[0]) cmd_sh <= {cmd_sh[CMD_BITS-2:0], 1'b0};
        if (state == ST_RD && step[0])  data_sh <= {data_sh[WORD_BITS-2:0], ee_do_i};
        if (step != last_step) begin
          step <= step + 1'b1;
        end else begin
          step <= '0;
          case (state)
            ST_PRE:  state <= ST_CMD;
            ST_CMD:  state <= ST_RD;
            ST_RD:   state <= ST_POST;
            default: begin
              state  <= ST_IDLE;
              busy_o <= 1'b0;
              done_o <= 1'b1;
              data_o <= data_sh;
            end
          endcase
        end
      end
    end
  end

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && state == ST_PRE) |=> $stable(cmd_sh)); // R7
  AST_SK_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk_o != $past(ee_sk_o)) |-> (cnt == CW'(1))); // R5
  AST_DI_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_di_o |-> ee_cs_o); // R8
endmodule

// File: tb/mw_eeprom_reader_tb.sv
module mw_eeprom_reader_tb;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ee_do_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic busy_o, done_o, ee_cs_o, ee_sk_o, ee_di_o;
  logic [15:0] data_o;

  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  mw_eeprom_reader #(.CLK_HZ(250_000_000), .PHASE_NS(16), .IDLE_PAIRS(26)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
    .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o), .ee_do_i(ee_do_i));

  function automatic logic [15:0] word_of(input logic [5:0] a);
    return 16'({10'b0, a} * 16'h9E37) ^ 16'h5AC3;
  endfunction

  // EEPROM model: frame bookkeeping and data return
  int rises = 0, frames = 0, base = 0, last_rises = 0, prev_rises = 0;
  logic [10:0] cmd_sh = '0, last_cmd = '0;
  logic [15:0] w;
  always @(posedge ee_sk_o or negedge ee_cs_o) begin
    if (!ee_cs_o) begin
      prev_rises = last_rises;
      last_rises = rises;
      last_cmd   = cmd_sh;
      rises      = 0;
      cmd_sh     = '0;
      frames++;
    end else begin
      rises++;
      if (rises <= 11) cmd_sh = {cmd_sh[9:0], ee_di_o};
      if (rises >= 12 && rises <= 27) begin
        w = word_of(cmd_sh[5:0]);
        ee_do_i <= w[27 - rises];
      end
    end
  end

  // pin monitors: command line quiet, phase widths
  int  run = 0;
  logic sk_prev = 1'b0, di_bad = 1'b0, phase_bad = 1'b0;
  always @(negedge clk) begin
    if (ee_di_o && !(frames == base + 1 && (rises < 11 || (rises == 11 && ee_sk_o))))
      di_bad <= 1'b1;
    if (!ee_cs_o) begin
      run <= 0;
    end else if (ee_sk_o != sk_prev) begin
      if (sk_prev && run != P) phase_bad <= 1'b1;
      if (!sk_prev && run < P) phase_bad <= 1'b1;
      run <= 1;
    end else begin
      run <= run + 1;
    end
    sk_prev <= ee_sk_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_read(input logic [5:0] a, input logic [10:0] exp_cmd, input bit poke);
    int n = 0;
    int dones = 0;
    @(negedge clk);
    base = frames; di_bad = 1'b0; phase_bad = 1'b0;
    start_i = 1'b1; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    check("R6 busy after start", busy_o, 1);
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 300) begin start_i = 1'b1; addr_i = ~a; end
      if (poke && n == 301) start_i = 1'b0;
    end
    check("R6 done seen", done_o, 1);
    check("R6 busy low at done", busy_o, 0);
    check("R2 data word", data_o, word_of(a));
    check("R1 command", last_cmd, exp_cmd);
    check("R3 pre flush rises", prev_rises, 26);
    check("R4 post flush rises", last_rises, 27 + 26);
    check("R3 two frames", frames - base, 2);
    check("R8 di quiet", di_bad, 0);
    check("R5 phase widths", phase_bad, 0);
    @(negedge clk);
    check("R6 done single", done_o, 0);
    for (int k = 0; k < 20; k++) @(negedge clk);
    check("R7 no extra access", busy_o, 0);
    check("R6 data held", data_o, word_of(a));
  endtask

  localparam logic [5:0]  VA [8] = '{6'd6, 6'd7, 6'd8, 6'd9, 6'd0, 6'd63, 6'd42, 6'd21};
  localparam logic [10:0] VC [8] = '{11'h186, 11'h187, 11'h188, 11'h189,
                                      11'h180, 11'h1BF, 11'h1AA, 11'h195};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset busy", busy_o, 0);
    check("R9 reset done", done_o, 0);
    check("R9 reset data", data_o, 0);
    check("R9 reset pins", {ee_cs_o, ee_sk_o, ee_di_o}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) run_read(VA[i], VC[i], 1'b0);
    run_read(6'd9, 11'h189, 1'b1); // R7 start while busy
    // R9 reset mid-access
    @(negedge clk); start_i = 1'b1; addr_i = 6'd5;
    @(negedge clk); start_i = 1'b0;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 abort busy", busy_o, 0);
    check("R9 abort data", data_o, 0);
    @(negedge clk);
    check("R9 abort pins", {ee_cs_o, ee_sk_o, ee_di_o}, 0);
    rst_n = 1'b1;
    run_read(6'd8, 11'h188, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule